// File: doc/BRIEF.md
# Transmit/Receive DMA Request Arbiter

This block decides which of two requesters, the transmit path or the receive path, gets the single shared bus-master DMA engine next. Each requester raises a level request. When the engine is idle and DMA is enabled, the arbiter issues one registered, one-hot grant. The grant stays asserted until the engine pulses a transfer-done strobe.

A four-bit control register selects the policy used when both requests are pending. The policy is fixed transmit priority, fixed receive priority, or fair alternation. A live comparison of the transmit FIFO fill level against a programmable low-watermark overrides the policy toward transmit whenever the FIFO is about to run dry. The same register holds the master DMA enable. It also holds a debug single-shot mode, in which the enable clears itself as each transfer completes, so software can step the engine one transfer at a time.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, every control bit reads 0, the whole read word is 0, and both grants are 0.
- R2: Control word layout: bit 0 is DMA enable, bit 1 is receive preference, bit 2 is transmit preference and bit 3 is single-shot mode. A write takes effect on the next clock edge. Bits 31:4 always read as 0, whatever was written to them.
- R3: No grant is issued while the DMA enable bit is 0, even with both requests pending.
- R4: With both requests pending and the transmit-preference bit set, transmit is granted.
- R5: With both requests pending, receive preference set and no transmit preference in effect (neither the bit nor the watermark force), receive is granted.
- R6: When both preference bits are set, transmit wins.
- R7: With both preference bits clear and no force, the two requests alternate. After each completed transfer, the turn passes to the requester that was not just served. The first turn after reset belongs to transmit.
- R8: While the transmit FIFO level is strictly below the threshold, transmit preference is forced on. At a level equal to the threshold there is no force.
- R9: Grants are one-hot or idle. A grant appears on the clock edge after an enabled, idle arbiter sees a request. It is held until a transfer-done strobe, drops on the following edge, and a new grant can follow one cycle later. A done strobe while no grant is active has no effect.
- R10: In single-shot mode, the enable bit clears on the edge that completes a transfer. If a register write lands in the same cycle, the clear wins for the enable bit, and the other bits take the written values.
- R11: A lone pending request is granted whatever the preference settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| tx_req | input | 1 | Transmit DMA request |
| rx_req | input | 1 | Receive DMA request |
| tx_fifo_level | input | LVL_W | Transmit FIFO fill level |
| tx_low_mark | input | LVL_W | Threshold below which transmit is forced |
| xfer_done | input | 1 | Transfer-complete strobe from the DMA engine |
| grant_tx | output | 1 | Engine granted to transmit |
| grant_rx | output | 1 | Engine granted to receive |

## Verification
The arbitration is tried with lone requests, simultaneous requests under each of the four preference-bit combinations, and simultaneous requests with the FIFO level just below and exactly at the threshold. This separates a fixed-priority decision from a watermark override and catches an off-by-one in the comparison. A run of simultaneous requests with no preference shows whether the turn really alternates and whether it starts at transmit. Long-held grants and done strobes sent while idle show that grant release follows only a completed transfer. The single-shot runs, including a write that collides with the auto-clear, show which update wins on the enable bit.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int REG_W = 32;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic single_shot; // bit 3
    logic tx_pref;     // bit 2
    logic rx_pref;     // bit 1
    logic dma_en;      // bit 0
  } ctl_t;

  // Returns 1 when transmit should be served, given at least one request.
  function automatic logic pick_tx(input logic tx_req, input logic rx_req,
                                   input logic tx_pref_eff, input logic rx_pref,
                                   input logic turn_tx);
    logic win;
    if (!rx_req)           win = tx_req;
    else if (!tx_req)      win = 1'b0;
    else if (tx_pref_eff)  win = 1'b1;
    else if (rx_pref)      win = 1'b0;
    else                   win = turn_tx;
    return win;
  endfunction

  function automatic logic level_below(input int unsigned level,
                                       input int unsigned mark);
    return level < mark;
  endfunction

endpackage

// File: rtl/arb_ctl_reg.sv
module arb_ctl_reg
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             xfer_complete,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata
);

  logic auto_clear;
  logic unused_wbits;

  assign auto_clear   = ctl.single_shot && xfer_complete;
  assign unused_wbits = ^wdata[REG_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_en) ctl <= ctl_t'(wdata[CTL_W-1:0]);
      if (auto_clear) ctl.dma_en <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CTL_W-1:0] = ctl;
  end

  // R10: single-shot completion always leaves the enable cleared
  assert_single_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.single_shot && xfer_complete) |=> !ctl.dma_en);

endmodule

// File: rtl/arb_watermark.sv
module arb_watermark #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mark,
  output logic             force_tx
);

  assign force_tx = dma_arb_pkg::level_below(int'(level), int'(mark));

endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic tx_pref_eff,
  input  logic rx_pref,
  input  logic tx_req,
  input  logic rx_req,
  input  logic xfer_done,
  output logic grant_tx,
  output logic grant_rx,
  output logic xfer_complete
);

  logic busy;
  logic turn_tx;
  logic launch;
  logic win_tx;

  assign busy          = grant_tx || grant_rx;
  assign xfer_complete = busy && xfer_done;
  assign launch        = !busy && dma_en && (tx_req || rx_req);
  assign win_tx        = pick_tx(tx_req, rx_req, tx_pref_eff, rx_pref, turn_tx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_tx <= 1'b0;
      grant_rx <= 1'b0;
      turn_tx  <= 1'b1;
    end else if (xfer_complete) begin
      grant_tx <= 1'b0;
      grant_rx <= 1'b0;
      turn_tx  <= grant_rx;
    end else if (launch) begin
      grant_tx <= win_tx;
      grant_rx <= !win_tx;
    end
  end

  // R9: never both grants at once
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_tx, grant_rx}));

  // R3: no new grant while disabled
  assert_no_grant_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !dma_en) |=> !(grant_tx || grant_rx));

  // R9: grant held while no done
  assert_grant_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> ($stable(grant_tx) && $stable(grant_rx)));

  // R9: grant released after done
  assert_grant_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_complete |=> !(grant_tx || grant_rx));

  // R4 / R8: transmit preference wins a pending transmit request
  assert_tx_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dma_en && tx_req && tx_pref_eff) |=> grant_tx);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tx_req,
  input  logic             rx_req,
  input  logic [LVL_W-1:0] tx_fifo_level,
  input  logic [LVL_W-1:0] tx_low_mark,
  input  logic             xfer_done,
  output logic             grant_tx,
  output logic             grant_rx
);

  ctl_t ctl;
  logic force_tx;
  logic tx_pref_eff;
  logic xfer_complete;

  arb_ctl_reg u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (reg_wr_en),
    .wdata         (reg_wdata),
    .xfer_complete (xfer_complete),
    .ctl           (ctl),
    .rdata         (reg_rdata)
  );

  arb_watermark #(.LVL_W(LVL_W)) u_mark (
    .level    (tx_fifo_level),
    .mark     (tx_low_mark),
    .force_tx (force_tx)
  );

  assign tx_pref_eff = ctl.tx_pref || force_tx;

  arb_grant_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_en        (ctl.dma_en),
    .tx_pref_eff   (tx_pref_eff),
    .rx_pref       (ctl.rx_pref),
    .tx_req        (tx_req),
    .rx_req        (rx_req),
    .xfer_done     (xfer_done),
    .grant_tx      (grant_tx),
    .grant_rx      (grant_rx),
    .xfer_complete (xfer_complete)
  );

  // R8: below-watermark level forces transmit ahead of receive preference
  assert_force_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_tx && !grant_rx && ctl.dma_en && tx_req && rx_req && force_tx)
      |=> grant_tx);

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;

  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             tx_req = 1'b0;
  logic             rx_req = 1'b0;
  logic [LVL_W-1:0] tx_fifo_level = 8'd100;
  logic [LVL_W-1:0] tx_low_mark = 8'd10;
  logic             xfer_done = 1'b0;
  logic             grant_tx;
  logic             grant_rx;

  dma_req_arbiter #(.LVL_W(LVL_W)) dut_i (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_reg;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations in their due cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_reg ? reg_rdata : {30'd0, grant_rx, grant_tx};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_now(bit is_reg, logic [31:0] e, string tag, int ahead);
    item_t it;
    it.due = cyc + ahead; it.is_reg = is_reg; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // one transfer: request, expect grant {rx,tx}, complete
  task automatic xfer(bit t, bit r, bit et, bit er, string tag);
    tx_req = t; rx_req = r;
    expect_now(0, {30'd0, er, et}, tag, 1);
    @(negedge clk);
    xfer_done = 1'b1;
    expect_now(0, 32'd0, {tag, " release"}, 1);
    @(negedge clk);
    xfer_done = 1'b0; tx_req = 0; rx_req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now(1, 32'd0, "R1 reset rdata", 0);
    expect_now(0, 32'd0, "R1 reset grants", 0);
    @(negedge clk);

    wr(32'hFFFF_FFF2);
    expect_now(1, 32'h2, "R2 layout and reserved zero", 0);
    tx_req = 1; rx_req = 1;
    expect_now(0, 32'd0, "R3 disabled no grant", 1);
    @(negedge clk);
    expect_now(0, 32'd0, "R3 disabled no grant later", 1);
    @(negedge clk);
    tx_req = 0; rx_req = 0;
    @(negedge clk);

    wr(32'h5);  xfer(1, 1, 1, 0, "R4 tx preference");
    wr(32'h3);  xfer(1, 1, 0, 1, "R5 rx preference");
    wr(32'h7);  xfer(1, 1, 1, 0, "R6 both prefs tx wins");
    wr(32'h5);  xfer(0, 1, 0, 1, "R11 lone rx");
    wr(32'h3);
    tx_fifo_level = 8'd9;  xfer(1, 1, 1, 0, "R8 below mark forces tx");
    tx_fifo_level = 8'd10; xfer(1, 1, 0, 1, "R8 at mark no force");
    tx_fifo_level = 8'd100;

    wr(32'h1);
    xfer(1, 1, 1, 0, "R7 rr turn tx");
    xfer(1, 1, 0, 1, "R7 rr turn rx");
    xfer(1, 1, 1, 0, "R7 rr turn tx again");

    // hold: grant stays until done (turn now rx)
    tx_req = 1; rx_req = 1;
    expect_now(0, 32'h2, "R9 grant issued", 1);
    @(negedge clk);
    tx_req = 0; rx_req = 0;
    expect_now(0, 32'h2, "R9 grant held", 3);
    repeat (3) @(negedge clk);
    xfer_done = 1;
    expect_now(0, 32'd0, "R9 grant released", 1);
    @(negedge clk);
    xfer_done = 1'b1;
    expect_now(0, 32'd0, "R9 idle done ignored", 1);
    expect_now(1, 32'h1, "R9 idle done keeps enable", 1);
    @(negedge clk);
    xfer_done = 1'b0;
    @(negedge clk);

    // single-shot (turn is tx after rx served)
    wr(32'h9);
    xfer(1, 1, 1, 0, "R10 single-shot grant");
    expect_now(1, 32'h8, "R10 enable auto-cleared", 0);
    xfer(1, 0, 0, 0, "R10 no grant after auto-clear");

    wr(32'h9);
    tx_req = 1;
    expect_now(0, 32'h1, "R10 grant before collision", 1);
    @(negedge clk);
    tx_req = 0;
    xfer_done = 1; reg_wr_en = 1; reg_wdata = 32'hB;
    expect_now(1, 32'hA, "R10 auto-clear beats write", 1);
    @(negedge clk);
    xfer_done = 0; reg_wr_en = 0;
    repeat (3) @(negedge clk);
    done_run = 1;
  end

  initial begin
    wait (done_run || cyc > 20000);
    if (!done_run) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    end
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule